// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns software interrupt requests between processors into per-target, per-source pending state. A processor writes a trigger word naming one of sixteen interrupt numbers, a filter mode and a list of target processors. For every processor the filter selects, the block records the requester as a source of that interrupt. Each target therefore holds, for every interrupt number, a byte-wide mask of the processors that raised it, and the interrupt counts as pending while that mask is non-zero.

Two register windows expose the source masks of the accessing processor, four interrupts per 32-bit word. Writes to the first window add source bits and writes to the second remove them, and both report whether any stored bit moved. A drain port walks one target/interrupt pair in a single ascending pass over its sources. It offers each remaining source to a delivery slot for one cycle, retires the sources the slot takes, and reports whether the mask ended empty. Up to eight processors are supported, and `cpu_count` gives how many are online.

Top module: `sgi_dispatch`

## Requirements
- R1: A write with `reg_sel`=0 is a trigger: bits [3:0] pick the interrupt, bits [25:24] the filter and bits [23:16] a target list (bit n = processor n). Filter 0 targets the listed processors that are online (index < `cpu_count`), and a write whose list is zero changes nothing.
- R2: Filter 1 targets every online processor except the requester `reg_cpu`.
- R3: Filter 2 targets only the requester, whatever the list holds.
- R4: Filter 3 is reserved, and a trigger using it changes no stored state.
- R5: For each target t, bit `reg_cpu` is ORed into the source mask of (t, interrupt). `pending[t*16+i]` is high exactly while the mask of target t, interrupt i is non-zero.
- R6: A read with `reg_sel`=0 returns zero on `reg_rdata` in the following cycle.
- R7: A read with `reg_sel`=1 or 2 returns, one cycle later, the masks of processor `reg_cpu`: word `reg_word`=w, byte k (bits 8k+7..8k) is interrupt 4w+k, and bit n of a byte is source n.
- R8: A write with `reg_sel`=1 ORs each byte of `reg_wdata` into the matching mask, and `reg_sel`=2 clears the bits set in each byte. `reg_changed` is high in the next cycle only if some stored bit actually changed. `reg_sel`=3 reads zero and ignores writes.
- R9: After `drain_req` with (`drain_cpu`, `drain_sgi`) while idle, the block offers the remaining sources one per cycle in ascending order, each once, on `offer_valid`/`offer_src`. A source is cleared when `offer_accept` is high in its offer cycle, and a declined source stays set.
- R10: One cycle after the pass finds no further source, `drain_done` pulses with `drain_busy` low. `drain_clean` is then high exactly when the mask is empty, which has also dropped the pending flag.
- R11: A trigger or window write in the same cycle as an accepted offer on the same mask applies both updates. A source added above the current scan point during the pass is offered in that same pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_count | input | 4 | Number of online processors (1..8) |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 trigger, 1 set window, 2 clear window, 3 unused |
| reg_word | input | 2 | Window word index (four interrupts per word) |
| reg_cpu | input | 3 | Accessing / requesting processor |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read |
| reg_changed | output | 1 | A window write changed a stored bit (one cycle later) |
| drain_req | input | 1 | Start a drain pass |
| drain_cpu | input | 3 | Target processor to drain |
| drain_sgi | input | 4 | Interrupt number to drain |
| drain_busy | output | 1 | Drain pass in progress |
| offer_valid | output | 1 | A source is offered this cycle |
| offer_cpu | output | 3 | Target of the offered interrupt |
| offer_sgi | output | 4 | Interrupt number offered |
| offer_src | output | 3 | Source processor offered |
| offer_accept | input | 1 | Delivery slot takes the offer |
| drain_done | output | 1 | Pass finished (one-cycle pulse) |
| drain_clean | output | 1 | Mask was empty at the end of the pass |
| pending | output | 128 | Pending flag per target and interrupt, index t*16+i |

## Verification
A drain retire and a register update can land on the same source mask in the same cycle. The bench provokes this by issuing a trigger that targets the drained mask in exactly the cycle its lowest source is offered and accepted. It expects the accepted source gone and the new requester present. The new source lies above the scan point, so the scoreboard also expects it to be offered later in the same pass, and the pass to end unclean when that offer is declined.

// File: rtl/sgi_dispatch_pkg.sv
// Shared encodings for the software-interrupt dispatcher.
package sgi_dispatch_pkg;
    // Register window select codes on reg_sel.
    localparam logic [1:0] SEL_TRIGGER = 2'd0;
    localparam logic [1:0] SEL_SETWIN  = 2'd1;
    localparam logic [1:0] SEL_CLRWIN  = 2'd2;

    // Target filter codes in trigger word bits [25:24].
    localparam logic [1:0] FILT_LIST   = 2'd0;
    localparam logic [1:0] FILT_OTHERS = 2'd1;
    localparam logic [1:0] FILT_SELF   = 2'd2;

    // Drain sequencer states.
    typedef enum logic {DR_IDLE, DR_SCAN} drain_state_e;
endpackage

// File: rtl/sgi_target_decode.sv
// Decodes a trigger word into a target processor mask.
// Assumes: list field at bit 16, filter at [25:24], interrupt number in the
// low bits; NUM_CPU <= 8. Purely combinational.
module sgi_target_decode #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int CNT_W = $clog2(NUM_CPU + 1),
    localparam int SGI_W = $clog2(NUM_SGI)
) (
    input  logic               wr_en,
    input  logic [31:0]        wdata,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [CNT_W-1:0]   cpu_count,
    output logic               fire,
    output logic [NUM_CPU-1:0] targets,
    output logic [SGI_W-1:0]   sgi_id
);
    import sgi_dispatch_pkg::*;

    logic [NUM_CPU-1:0] online;
    logic [NUM_CPU-1:0] self_bit;
    logic [NUM_CPU-1:0] list;

    // Build the online mask and apply the filter mode.
    always_comb begin
        for (int i = 0; i < NUM_CPU; i++) begin
            online[i] = (CNT_W'(i) < cpu_count);
        end
        self_bit = NUM_CPU'(1) << req_cpu;
        list     = wdata[16 +: NUM_CPU];
        case (wdata[25:24])
            FILT_LIST:   targets = list & online;
            FILT_OTHERS: targets = online & ~self_bit;
            FILT_SELF:   targets = self_bit;
            default:     targets = '0;
        endcase
        fire   = wr_en && (targets != '0);
        sgi_id = wdata[SGI_W-1:0];
    end
endmodule

// File: rtl/sgi_source_store.sv
// Holds the per-target, per-interrupt source masks and merges all updates
// (trigger, window set/clear, drain retire) into one next-state value.
// Assumes: NUM_SGI is a power of two, at least 4; NUM_CPU <= 8.
// A clear-window write wins over a same-cycle trigger on the same bit.
module sgi_source_store #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int SGI_W  = $clog2(NUM_SGI),
    localparam int WORD_W = (NUM_SGI > 4) ? $clog2(NUM_SGI / 4) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig_fire,
    input  logic [NUM_CPU-1:0]      trig_targets,
    input  logic [SGI_W-1:0]        trig_sgi,
    input  logic [CPU_W-1:0]        trig_src,
    input  logic                    win_wr,
    input  logic                    win_rd,
    input  logic                    win_set,
    input  logic [CPU_W-1:0]        win_cpu,
    input  logic [WORD_W-1:0]       win_word,
    input  logic [31:0]             win_data,
    input  logic                    drn_clr,
    input  logic [CPU_W-1:0]        drn_cpu,
    input  logic [SGI_W-1:0]        drn_sgi,
    input  logic [CPU_W-1:0]        drn_src,
    output logic [NUM_CPU-1:0][NUM_SGI-1:0][NUM_CPU-1:0] src_q,
    output logic [NUM_CPU-1:0][NUM_SGI-1:0][NUM_CPU-1:0] src_nxt,
    output logic [31:0]             rdata,
    output logic                    changed
);
    logic [31:0]        rd_c;
    logic               chg_c;
    logic [NUM_CPU-1:0] cur_b;
    logic [NUM_CPU-1:0] mask_b;

    // Merge every update source into the next mask array.
    always_comb begin
        src_nxt = src_q;
        for (int t = 0; t < NUM_CPU; t++) begin
            for (int s = 0; s < NUM_SGI; s++) begin
                if (trig_fire && trig_targets[t] && trig_sgi == SGI_W'(s))
                    src_nxt[t][s][trig_src] = 1'b1;
                if (win_wr && win_cpu == CPU_W'(t) && win_word == WORD_W'(s / 4)) begin
                    if (win_set)
                        src_nxt[t][s] = src_nxt[t][s] | win_data[8*(s%4) +: NUM_CPU];
                    else
                        src_nxt[t][s] = src_nxt[t][s] & ~win_data[8*(s%4) +: NUM_CPU];
                end
                if (drn_clr && drn_cpu == CPU_W'(t) && drn_sgi == SGI_W'(s))
                    src_nxt[t][s][drn_src] = 1'b0;
            end
        end
    end

    // Window read view and change detection for the addressed word.
    always_comb begin
        rd_c  = '0;
        chg_c = 1'b0;
        for (int k = 0; k < 4; k++) begin
            cur_b  = src_q[win_cpu][{win_word, 2'(k)}];
            mask_b = win_data[8*k +: NUM_CPU];
            rd_c[8*k +: NUM_CPU] = cur_b;
            if (win_set) chg_c = chg_c | (|(mask_b & ~cur_b));
            else         chg_c = chg_c | (|(mask_b & cur_b));
        end
    end

    // Register the masks, read data and change flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            rdata   <= '0;
            changed <= 1'b0;
        end else begin
            src_q   <= src_nxt;
            rdata   <= win_rd ? rd_c : 32'd0;
            changed <= win_wr && chg_c;
        end
    end
endmodule

// File: rtl/sgi_drain_ctrl.sv
// Single ascending pass over one source mask, offering each remaining
// source for one cycle and retiring it when the slot accepts.
// Assumes: cur_byte/nxt_byte are the current and next value of the mask
// selected by cpu_q/sgi_q. Requests while a pass runs are ignored.
module sgi_drain_ctrl #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int SGI_W = $clog2(NUM_SGI),
    localparam int PTR_W = CPU_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CPU_W-1:0]   start_cpu,
    input  logic [SGI_W-1:0]   start_sgi,
    input  logic [NUM_CPU-1:0] cur_byte,
    input  logic [NUM_CPU-1:0] nxt_byte,
    input  logic               accept,
    output logic               busy,
    output logic [CPU_W-1:0]   cpu_q,
    output logic [SGI_W-1:0]   sgi_q,
    output logic               offer_valid,
    output logic [CPU_W-1:0]   offer_src,
    output logic               clr,
    output logic               done,
    output logic               clean
);
    import sgi_dispatch_pkg::*;

    drain_state_e       state;
    logic [PTR_W-1:0]   ptr;
    logic [NUM_CPU-1:0] cand;
    logic               found;

    // Find the lowest remaining source at or above the scan point.
    always_comb begin
        for (int i = 0; i < NUM_CPU; i++) begin
            cand[i] = cur_byte[i] && (PTR_W'(i) >= ptr);
        end
        found     = |cand;
        offer_src = '0;
        for (int i = NUM_CPU - 1; i >= 0; i--) begin
            if (cand[i]) offer_src = CPU_W'(i);
        end
        busy        = (state == DR_SCAN);
        offer_valid = busy && found;
        clr         = offer_valid && accept;
    end

    // Pass sequencing and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DR_IDLE;
            ptr   <= '0;
            cpu_q <= '0;
            sgi_q <= '0;
            done  <= 1'b0;
            clean <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                DR_IDLE: begin
                    if (start) begin
                        cpu_q <= start_cpu;
                        sgi_q <= start_sgi;
                        ptr   <= '0;
                        state <= DR_SCAN;
                    end
                end
                default: begin
                    if (found) begin
                        ptr <= PTR_W'(offer_src) + PTR_W'(1);
                    end else begin
                        state <= DR_IDLE;
                        done  <= 1'b1;
                        clean <= (nxt_byte == '0);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sgi_dispatch.sv
// Top of the software-interrupt dispatcher: decodes register accesses,
// keeps per-source pending masks and runs drain passes.
// Assumes: one register access per cycle; reads return a cycle later.
module sgi_dispatch #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int CNT_W  = $clog2(NUM_CPU + 1),
    localparam int SGI_W  = $clog2(NUM_SGI),
    localparam int WORD_W = (NUM_SGI > 4) ? $clog2(NUM_SGI / 4) : 1,
    localparam int PEND_W = NUM_CPU * NUM_SGI
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cpu_count,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [1:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_word,
    input  logic [CPU_W-1:0]  reg_cpu,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_changed,
    input  logic              drain_req,
    input  logic [CPU_W-1:0]  drain_cpu,
    input  logic [SGI_W-1:0]  drain_sgi,
    output logic              drain_busy,
    output logic              offer_valid,
    output logic [CPU_W-1:0]  offer_cpu,
    output logic [SGI_W-1:0]  offer_sgi,
    output logic [CPU_W-1:0]  offer_src,
    input  logic              offer_accept,
    output logic              drain_done,
    output logic              drain_clean,
    output logic [PEND_W-1:0] pending
);
    import sgi_dispatch_pkg::*;

    logic               trig_wr;
    logic               win_sel;
    logic               win_wr;
    logic               win_rd;
    logic               trig_fire;
    logic [NUM_CPU-1:0] trig_targets;
    logic [SGI_W-1:0]   trig_sgi;
    logic               drn_clr;
    logic [NUM_CPU-1:0] drain_cur_byte;
    logic [NUM_CPU-1:0] drain_nxt_byte;
    logic [NUM_CPU-1:0][NUM_SGI-1:0][NUM_CPU-1:0] src_q;
    logic [NUM_CPU-1:0][NUM_SGI-1:0][NUM_CPU-1:0] src_nxt;

    // Split a register access into trigger and window strobes.
    always_comb begin
        win_sel = (reg_sel == SEL_SETWIN) || (reg_sel == SEL_CLRWIN);
        trig_wr = reg_valid && reg_write && (reg_sel == SEL_TRIGGER);
        win_wr  = reg_valid && reg_write && win_sel;
        win_rd  = reg_valid && !reg_write && win_sel;
    end

    sgi_target_decode #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_decode (
        .wr_en     (trig_wr),
        .wdata     (reg_wdata),
        .req_cpu   (reg_cpu),
        .cpu_count (cpu_count),
        .fire      (trig_fire),
        .targets   (trig_targets),
        .sgi_id    (trig_sgi)
    );

    sgi_source_store #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_fire    (trig_fire),
        .trig_targets (trig_targets),
        .trig_sgi     (trig_sgi),
        .trig_src     (reg_cpu),
        .win_wr       (win_wr),
        .win_rd       (win_rd),
        .win_set      (reg_sel == SEL_SETWIN),
        .win_cpu      (reg_cpu),
        .win_word     (reg_word),
        .win_data     (reg_wdata),
        .drn_clr      (drn_clr),
        .drn_cpu      (offer_cpu),
        .drn_sgi      (offer_sgi),
        .drn_src      (offer_src),
        .src_q        (src_q),
        .src_nxt      (src_nxt),
        .rdata        (reg_rdata),
        .changed      (reg_changed)
    );

    // Select the mask under drain, current and next value.
    always_comb begin
        drain_cur_byte = src_q[offer_cpu][offer_sgi];
        drain_nxt_byte = src_nxt[offer_cpu][offer_sgi];
    end

    sgi_drain_ctrl #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (drain_req),
        .start_cpu   (drain_cpu),
        .start_sgi   (drain_sgi),
        .cur_byte    (drain_cur_byte),
        .nxt_byte    (drain_nxt_byte),
        .accept      (offer_accept),
        .busy        (drain_busy),
        .cpu_q       (offer_cpu),
        .sgi_q       (offer_sgi),
        .offer_valid (offer_valid),
        .offer_src   (offer_src),
        .clr         (drn_clr),
        .done        (drain_done),
        .clean       (drain_clean)
    );

    // Pending flag per target/interrupt is the OR of its source mask.
    for (genvar t = 0; t < NUM_CPU; t++) begin : g_pend_t
        for (genvar s = 0; s < NUM_SGI; s++) begin : g_pend_s
            assign pending[t*NUM_SGI + s] = |src_q[t][s];
        end
    end
endmodule

// File: rtl/sgi_dispatch_checks.sv
// Temporal checks for the dispatcher, attached to every instance by bind.
module sgi_dispatch_checks #(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int PEND_W = NUM_CPU * NUM_SGI
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_valid,
    input logic               reg_write,
    input logic [1:0]         reg_sel,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic               reg_changed,
    input logic               drain_busy,
    input logic               offer_valid,
    input logic [CPU_W-1:0]   offer_src,
    input logic               drain_done,
    input logic [NUM_CPU-1:0] drain_cur_byte,
    input logic [PEND_W-1:0]  pending
);
    // R9: offers only happen inside a pass
    assert_offer_in_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> drain_busy);

    // R9: the offered source is really present in the mask
    assert_offer_present_R9: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> drain_cur_byte[offer_src]);

    // R6: trigger reads return zero
    assert_trigger_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_sel == 2'd0) |=> (reg_rdata == 32'd0));

    // R4: reserved filter leaves pending state alone when no retire happens
    assert_reserved_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_sel == 2'd0 && reg_wdata[25:24] == 2'd3 && !offer_valid)
        |=> (pending == $past(pending)));

    // R10: completion is reported with the pass already closed
    assert_done_closes_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> !drain_busy);

    // R8: change flag only follows a window write
    assert_changed_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_changed |-> $past(reg_valid && reg_write && (reg_sel == 2'd1 || reg_sel == 2'd2)));
endmodule

bind sgi_dispatch sgi_dispatch_checks #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_valid      (reg_valid),
    .reg_write      (reg_write),
    .reg_sel        (reg_sel),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .reg_changed    (reg_changed),
    .drain_busy     (drain_busy),
    .offer_valid    (offer_valid),
    .offer_src      (offer_src),
    .drain_done     (drain_done),
    .drain_cur_byte (drain_cur_byte),
    .pending        (pending)
);

// File: tb/sgi_dispatch_test.sv
`timescale 1ns/1ps
module sgi_dispatch_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   cpu_count = 4'd4;
    logic         reg_valid = 1'b0;
    logic         reg_write = 1'b0;
    logic [1:0]   reg_sel = 2'd3;
    logic [1:0]   reg_word = 2'd0;
    logic [2:0]   reg_cpu = 3'd0;
    logic [31:0]  reg_wdata = 32'd0;
    logic [31:0]  reg_rdata;
    logic         reg_changed;
    logic         drain_req = 1'b0;
    logic [2:0]   drain_cpu = 3'd0;
    logic [3:0]   drain_sgi = 4'd0;
    logic         drain_busy;
    logic         offer_valid;
    logic [2:0]   offer_cpu;
    logic [3:0]   offer_sgi;
    logic [2:0]   offer_src;
    logic         offer_accept = 1'b0;
    logic         drain_done;
    logic         drain_clean;
    logic [127:0] pending;

    int total = 0;
    int failed = 0;
    int exp_offers[$];
    logic [31:0]  rd_val;
    logic         chg_val;
    logic [127:0] pend_snap;

    always #2.5 clk = ~clk;

    sgi_dispatch uut (
        .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_sel(reg_sel),
        .reg_word(reg_word), .reg_cpu(reg_cpu), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_changed(reg_changed),
        .drain_req(drain_req), .drain_cpu(drain_cpu), .drain_sgi(drain_sgi),
        .drain_busy(drain_busy), .offer_valid(offer_valid), .offer_cpu(offer_cpu),
        .offer_sgi(offer_sgi), .offer_src(offer_src), .offer_accept(offer_accept),
        .drain_done(drain_done), .drain_clean(drain_clean), .pending(pending)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One register access; results are registered and read at the next negedge.
    task automatic reg_op(input logic [1:0] sel, input logic wr, input logic [2:0] cpu,
                          input logic [1:0] word, input logic [31:0] data);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_sel = sel;
        reg_cpu = cpu; reg_word = word; reg_wdata = data;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; reg_sel = 2'd3;
        rd_val  = reg_rdata;
        chg_val = reg_changed;
    endtask

    task automatic trigger(input logic [2:0] cpu, input logic [1:0] mode,
                           input logic [7:0] list, input logic [3:0] sgi);
        reg_op(2'd0, 1'b1, cpu, 2'd0, {6'd0, mode, list, 12'd0, sgi});
    endtask

    task automatic read_win(input logic [2:0] cpu, input logic [1:0] word);
        reg_op(2'd1, 1'b0, cpu, word, 32'd0);
    endtask

    task automatic drain_start(input logic [2:0] cpu, input logic [3:0] sgi);
        @(negedge clk);
        drain_req = 1'b1; drain_cpu = cpu; drain_sgi = sgi;
        @(negedge clk);
        drain_req = 1'b0;
    endtask

    // Answer offers with an accept mask until the pass reports completion.
    task automatic drain_finish(input logic [7:0] acc_mask, input logic exp_clean, input string tag);
        for (int n = 0; n < 40; n++) begin
            if (drain_done) break;
            offer_accept = offer_valid && acc_mask[offer_src];
            @(negedge clk);
        end
        offer_accept = 1'b0;
        check({tag, " done"}, {31'd0, drain_done}, 32'd1);
        check({tag, " clean"}, {31'd0, drain_clean}, {31'd0, exp_clean});
    endtask

    // Scoreboard monitor: every offer must match the next expected source.
    always @(negedge clk) begin
        if (rst_n && offer_valid) begin
            if (exp_offers.size() == 0) begin
                check("R9 unexpected offer", {29'd0, offer_src}, 32'hFFFF_FFFF);
            end else begin
                check("R9 offer order", {29'd0, offer_src}, exp_offers.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R5 reset pending", pending[31:0] | pending[127:96], 32'd0);
        check("R10 reset busy", {30'd0, drain_busy, offer_valid}, 32'd0);

        // R1: listed online targets
        trigger(3'd2, 2'd0, 8'h0A, 4'd3);
        check("R5 pending t1 sgi3", {31'd0, pending[1*16+3]}, 32'd1);
        check("R1 pending t3 sgi3", {31'd0, pending[3*16+3]}, 32'd1);
        check("R1 pending t0 sgi3", {31'd0, pending[0*16+3]}, 32'd0);
        read_win(3'd3, 2'd0);
        check("R7 source byte t3", rd_val, 32'h0400_0000);
        trigger(3'd0, 2'd0, 8'h30, 4'd3);
        check("R1 offline targets", {31'd0, pending[4*16+3]}, 32'd0);
        read_win(3'd1, 2'd0);
        check("R1 offline leaves t1", rd_val, 32'h0400_0000);
        trigger(3'd1, 2'd0, 8'h00, 4'd7);
        read_win(3'd1, 2'd1);
        check("R1 empty list ignored", rd_val, 32'd0);

        // R2: all online except requester
        trigger(3'd1, 2'd1, 8'h00, 4'd9);
        read_win(3'd0, 2'd2);
        check("R2 t0 sgi9", rd_val, 32'h0000_0200);
        read_win(3'd1, 2'd2);
        check("R2 requester excluded", rd_val, 32'd0);
        check("R2 pending t2 sgi9", {31'd0, pending[2*16+9]}, 32'd1);

        // R3: requester only
        trigger(3'd3, 2'd2, 8'hFF, 4'd15);
        read_win(3'd3, 2'd3);
        check("R3 self sgi15", rd_val, 32'h0800_0000);
        read_win(3'd0, 2'd3);
        check("R3 list ignored", rd_val, 32'd0);

        // R4: reserved filter
        pend_snap = pending;
        trigger(3'd0, 2'd3, 8'hFF, 4'd0);
        check("R4 pending unchanged", {31'd0, pending == pend_snap}, 32'd1);
        read_win(3'd1, 2'd0);
        check("R4 window unchanged", rd_val, 32'h0400_0000);

        // R6: trigger reads zero
        reg_op(2'd0, 1'b0, 3'd3, 2'd0, 32'd0);
        check("R6 trigger read", rd_val, 32'd0);

        // R8: set / clear windows and change flag
        reg_op(2'd1, 1'b1, 3'd2, 2'd1, 32'h0000_0381);
        check("R8 set changed", {31'd0, chg_val}, 32'd1);
        reg_op(2'd1, 1'b1, 3'd2, 2'd1, 32'h0000_0381);
        check("R8 repeat set no change", {31'd0, chg_val}, 32'd0);
        reg_op(2'd2, 1'b1, 3'd2, 2'd1, 32'h0000_0001);
        check("R8 clear changed", {31'd0, chg_val}, 32'd1);
        reg_op(2'd2, 1'b1, 3'd2, 2'd1, 32'h0000_0001);
        check("R8 repeat clear no change", {31'd0, chg_val}, 32'd0);
        reg_op(2'd2, 1'b0, 3'd2, 2'd1, 32'd0);
        check("R7 clear window read", rd_val, 32'h0000_0380);
        reg_op(2'd3, 1'b1, 3'd2, 2'd1, 32'hFFFF_FFFF);
        read_win(3'd2, 2'd1);
        check("R8 unused select ignored", rd_val, 32'h0000_0380);

        // R9/R10: full drain
        exp_offers.push_back(0); exp_offers.push_back(1);
        drain_start(3'd2, 4'd5);
        drain_finish(8'hFF, 1'b1, "R10 drain t2 sgi5");
        check("R10 pending dropped", {31'd0, pending[2*16+5]}, 32'd0);
        read_win(3'd2, 2'd1);
        check("R9 after drain", rd_val, 32'h0000_0080);

        // R9: declined source retained, then taken
        exp_offers.push_back(7);
        drain_start(3'd2, 4'd4);
        drain_finish(8'h00, 1'b0, "R9 declined");
        read_win(3'd2, 2'd1);
        check("R9 declined kept", rd_val, 32'h0000_0080);
        exp_offers.push_back(7);
        drain_start(3'd2, 4'd4);
        drain_finish(8'hFF, 1'b1, "R10 second pass");
        check("R10 pending t2 sgi4", {31'd0, pending[2*16+4]}, 32'd0);

        // R9: partial acceptance across several sources
        reg_op(2'd1, 1'b1, 3'd0, 2'd2, 32'h0000_1400);
        check("R8 add sources", {31'd0, chg_val}, 32'd1);
        exp_offers.push_back(1); exp_offers.push_back(2); exp_offers.push_back(4);
        drain_start(3'd0, 4'd9);
        drain_finish(8'h12, 1'b0, "R9 partial");
        read_win(3'd0, 2'd2);
        check("R9 partial remainder", rd_val, 32'h0000_0400);

        // R11: trigger lands in the same cycle as an accepted offer
        reg_op(2'd1, 1'b1, 3'd1, 2'd1, 32'h0000_0100);
        exp_offers.push_back(0); exp_offers.push_back(3);
        drain_start(3'd1, 4'd5);
        offer_accept = offer_valid && (offer_src == 3'd0);
        reg_valid = 1'b1; reg_write = 1'b1; reg_sel = 2'd0; reg_cpu = 3'd3;
        reg_wdata = {6'd0, 2'd0, 8'h02, 12'd0, 4'd5};
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; reg_sel = 2'd3;
        drain_finish(8'h01, 1'b0, "R11 concurrent");
        read_win(3'd1, 2'd1);
        check("R11 merged mask", rd_val, 32'h0000_0800);

        // R2 with all eight processors online
        cpu_count = 4'd8;
        trigger(3'd0, 2'd1, 8'h00, 4'd1);
        read_win(3'd7, 2'd0);
        check("R2 t7 sgi1", rd_val, 32'h0000_0100);
        check("R2 t0 excluded", {31'd0, pending[0*16+1]}, 32'd0);
        check("R2 t5 sgi1", {31'd0, pending[5*16+1]}, 32'd1);

        @(negedge clk);
        check("R9 all offers seen", exp_offers.size(), 32'd0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule